// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides, for every received CAN frame identifier, whether the frame is kept and which of two receive FIFOs it goes to. Two filter lists sit in a small word-addressed element store. One list is for 11-bit base identifiers. The other is for 29-bit extended identifiers. The frame's extended flag picks the list. Extended identifiers are first ANDed with a global mask register.

The chosen list is walked one element per clock, starting at element 0, and the walk stops at the first element that matches. Each element has an action and a match type. The action can disable the element, store the frame into FIFO 0, store it into FIFO 1, or reject the frame. The match type can be an inclusive range, two exact identifiers, or a mask compare. If no element matches, a programmable rule for that identifier kind decides the outcome, and the reported index is all ones.

Frames enter on a valid/ready stream. `frm_ready` is high only while the engine is idle, and a frame is taken on an edge where both `frm_valid` and `frm_ready` are high. The verdict leaves on a second valid/ready stream. Once `res_valid` rises, the verdict fields hold steady until an edge with `res_ready` high, and no new frame is taken before that edge. Configuration writes are plain single-cycle writes, meant to be issued only while the engine is idle.

Top module: `can_accept_filter`

## Requirements
- R1: `frm_ready` is high only while no frame is being scanned and no verdict is waiting. While `res_valid` is high and `res_ready` is low, `res_valid`, `res_accept`, `res_fifo` and `res_index` stay unchanged. One edge with `res_ready` high consumes the verdict and returns the engine to idle.
- R2: `frm_ide`=0 selects the base list, and only `frm_id[10:0]` is compared (zero-extended). `frm_ide`=1 selects the extended list.
- R3: Elements are tried in rising index order, and the first match ends the scan. `res_index` reports that element. Count the edges after the accepting edge: a hit on element k raises `res_valid` on edge k+1.
- R4: Type 00 (range) matches when id1 <= id <= id2, with both bounds included. If id1 > id2 the element never matches.
- R5: Type 01 (dual) matches when id equals id1 or id equals id2. Type 11 never matches.
- R6: Type 10 (mask) matches when (id & id2) == (id1 & id2). Here id1 is the pattern and id2 is the mask.
- R7: The 3-bit action works as follows: 001 stores to FIFO 0 (`res_accept`=1, `res_fifo`=0); 010 stores to FIFO 1 (`res_accept`=1, `res_fifo`=1); 011 rejects (`res_accept`=0, `res_fifo`=0). Actions 000 and 1xx disable the element, so it is skipped.
- R8: An extended identifier is ANDed with the mask register (word 45, bits [28:0], reset all ones) before it is compared.
- R9: When nothing matches, the list's 2-bit rule applies: 00 accepts to FIFO 0, 01 accepts to FIFO 1, and 1x rejects. `res_index` is then all ones (31).
- R10: Only elements below the list count are scanned. A count above the list size is clamped to the size. With count n and no hit, `res_valid` rises on edge n. With n = 0 it rises on the accepting edge itself.
- R11: Configuration addresses are byte addresses, and bits [1:0] are ignored. The word map is as follows. Words 0..27 hold base elements: [31:30] type, [29:27] action, [26:16] id1, [10:0] id2. Words 28+2e and 29+2e hold extended element e: word 0 has [31:29] action and [28:0] id1; word 1 has [31:30] type and [28:0] id2. Word 44 is the control word: [1:0] base rule, [3:2] extended rule, [12:8] base count, [19:16] extended count. Word 45 is the extended mask.
- R12: After reset, `frm_ready`=1 and `res_valid`=0. All elements are disabled, both counts are 0, both rules are 00, and the mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| frm_valid | input | 1 | Frame identifier valid |
| frm_ready | output | 1 | Engine can take a frame |
| frm_ide | input | 1 | 1 = extended identifier |
| frm_id | input | 29 | Received identifier |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict consumed |
| res_accept | output | 1 | 1 = store frame |
| res_fifo | output | 1 | Target FIFO (0 or 1) |
| res_index | output | 5 | Matching element, all ones if none |

## Verification
The bench aims at frames that match two elements, so that an engine which does not stop at the first hit reports the later index. It probes both range bounds and a reversed range, to catch an off-by-one or a wrap-around compare. Base frames are sent with high identifier bits set, which exposes a design that compares all 29 bits. An extended frame is sent that matches only once the mask is applied. The bench also checks exact latency for scans of count 0, of a clamped oversize count, and ending at the count limit; an engine that scans past the count shows a longer latency or a hit it should not reach. A stalled verdict is watched over several cycles to catch fields that change under back-pressure. Configuration writes use non-zero low address bits to catch a decoder that does not drop them.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  typedef enum logic [1:0] {
    FT_RANGE = 2'd0,
    FT_DUAL  = 2'd1,
    FT_MASK  = 2'd2,
    FT_NONE  = 2'd3
  } ftype_e;

  localparam logic [2:0] ACT_FIFO0  = 3'd1;
  localparam logic [2:0] ACT_FIFO1  = 3'd2;
  localparam logic [2:0] ACT_REJECT = 3'd3;

  typedef struct packed {
    ftype_e      ftype;
    logic [2:0]  act;
    logic [28:0] id1;
    logic [28:0] id2;
  } elem_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_HOLD = 2'd2
  } state_e;
endpackage

// File: rtl/can_flt_store.sv
module can_flt_store
  import can_flt_pkg::*;
#(
  parameter int STD_N = 28,
  parameter int EXT_N = 8,
  parameter int AW    = 6,
  parameter int IDXW  = 5,
  parameter int SCW   = 5,
  parameter int ECW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_word,
  input  logic [31:0]     wr_data,
  input  logic            rd_ext,
  input  logic [IDXW-1:0] rd_idx,
  output elem_t           rd_elem,
  output logic [28:0]     xmask,
  output logic [1:0]      s_rule,
  output logic [1:0]      e_rule,
  output logic [SCW-1:0]  s_cnt,
  output logic [ECW-1:0]  e_cnt
);
  localparam int WORDS  = STD_N + 2 * EXT_N;
  localparam int W_CTRL = WORDS;
  localparam int W_MASK = WORDS + 1;

  logic [31:0] mem [0:WORDS-1];
  logic [31:0] w0, w1;
  logic [AW-1:0] a0, a1;
  logic unused_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      xmask  <= '1;
      s_rule <= '0;
      e_rule <= '0;
      s_cnt  <= '0;
      e_cnt  <= '0;
    end else if (wr_en) begin
      if (32'(wr_word) < 32'(WORDS)) mem[wr_word] <= wr_data;
      else if (32'(wr_word) == 32'(W_CTRL)) begin
        s_rule <= wr_data[1:0];
        e_rule <= wr_data[3:2];
        s_cnt  <= wr_data[8 +: SCW];
        e_cnt  <= wr_data[16 +: ECW];
      end else if (32'(wr_word) == 32'(W_MASK)) xmask <= wr_data[28:0];
    end
  end

  // Element read: one base word, or a pair of words for an extended element.
  always_comb begin
    int base;
    base = rd_ext ? (STD_N + 2 * int'(rd_idx)) : int'(rd_idx);
    a0 = AW'(base);
    a1 = AW'(base + 1);
    w0 = mem[a0];
    w1 = mem[a1];
    if (rd_ext) begin
      rd_elem.act   = w0[31:29];
      rd_elem.id1   = w0[28:0];
      rd_elem.ftype = ftype_e'(w1[31:30]);
      rd_elem.id2   = w1[28:0];
    end else begin
      rd_elem.ftype = ftype_e'(w0[31:30]);
      rd_elem.act   = w0[29:27];
      rd_elem.id1   = {18'd0, w0[26:16]};
      rd_elem.id2   = {18'd0, w0[10:0]};
    end
  end

  assign unused_bits = ^{w0[15:11], w1[29]};
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
  import can_flt_pkg::*;
(
  input  elem_t       elem,
  input  logic [28:0] id,
  output logic        hit
);
  logic enabled;
  logic cmp;

  assign enabled = (elem.act == ACT_FIFO0) || (elem.act == ACT_FIFO1) ||
                   (elem.act == ACT_REJECT);

  always_comb begin
    unique case (elem.ftype)
      FT_RANGE: cmp = (id >= elem.id1) && (id <= elem.id2);
      FT_DUAL:  cmp = (id == elem.id1) || (id == elem.id2);
      FT_MASK:  cmp = ((id & elem.id2) == (elem.id1 & elem.id2));
      default:  cmp = 1'b0;
    endcase
  end

  assign hit = enabled && cmp;
endmodule

// File: rtl/can_flt_seq.sv
module can_flt_seq
  import can_flt_pkg::*;
#(
  parameter int STD_N = 28,
  parameter int EXT_N = 8,
  parameter int IDXW  = 5,
  parameter int SCW   = 5,
  parameter int ECW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frm_valid,
  output logic            frm_ready,
  input  logic            frm_ide,
  input  logic [28:0]     frm_id,
  input  logic [28:0]     xmask,
  input  logic [1:0]      s_rule,
  input  logic [1:0]      e_rule,
  input  logic [SCW-1:0]  s_cnt,
  input  logic [ECW-1:0]  e_cnt,
  input  logic            hit,
  input  logic [2:0]      hit_act,
  output logic            scan_ext,
  output logic [IDXW-1:0] scan_idx,
  output logic [28:0]     scan_id,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_accept,
  output logic            res_fifo,
  output logic [IDXW-1:0] res_index
);
  localparam logic [IDXW-1:0] NO_HIT = '1;

  state_e          st;
  logic [IDXW-1:0] cnt_q;
  logic [IDXW-1:0] cnt_n;
  logic            last;
  logic [1:0]      rule;

  always_comb begin
    int sc, ec;
    sc = int'(s_cnt);
    ec = int'(e_cnt);
    if (sc > STD_N) sc = STD_N;
    if (ec > EXT_N) ec = EXT_N;
    cnt_n = frm_ide ? IDXW'(ec) : IDXW'(sc);
  end

  assign last      = (32'(scan_idx) + 1) == 32'(cnt_q);
  assign rule      = scan_ext ? e_rule : s_rule;
  assign frm_ready = (st == S_IDLE);
  assign res_valid = (st == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt_q      <= '0;
      scan_idx   <= '0;
      scan_ext   <= 1'b0;
      scan_id    <= '0;
      res_accept <= 1'b0;
      res_fifo   <= 1'b0;
      res_index  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (frm_valid) begin
          scan_ext <= frm_ide;
          scan_id  <= frm_ide ? (frm_id & xmask) : {18'd0, frm_id[10:0]};
          cnt_q    <= cnt_n;
          scan_idx <= '0;
          if (cnt_n == '0) begin
            st         <= S_HOLD;
            res_accept <= ~(frm_ide ? e_rule[1] : s_rule[1]);
            res_fifo   <= frm_ide ? (e_rule == 2'b01) : (s_rule == 2'b01);
            res_index  <= NO_HIT;
          end else begin
            st <= S_SCAN;
          end
        end
        S_SCAN: if (hit) begin
          st         <= S_HOLD;
          res_accept <= (hit_act != ACT_REJECT);
          res_fifo   <= (hit_act == ACT_FIFO1);
          res_index  <= scan_idx;
        end else if (last) begin
          st         <= S_HOLD;
          res_accept <= ~rule[1];
          res_fifo   <= (rule == 2'b01);
          res_index  <= NO_HIT;
        end else begin
          scan_idx <= scan_idx + 1'b1;
        end
        S_HOLD: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: a miss that is not the last element moves to the next index
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && !hit && !last) |=> (st == S_SCAN && scan_idx == $past(scan_idx) + 1'b1));

  // R3: a hit ends the scan and reports that element
  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && hit) |=> (res_valid && res_index == $past(scan_idx)));

  // R10: the scan never reaches an element at or above the count
  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN) |-> (scan_idx < cnt_q));
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter  int STD_N = 28,
  parameter  int EXT_N = 8,
  localparam int WORDS = STD_N + 2 * EXT_N,
  localparam int AW    = $clog2(WORDS + 2),
  localparam int MAXN  = (STD_N > EXT_N) ? STD_N : EXT_N,
  localparam int IDXW  = $clog2(MAXN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW+1:0]   cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            frm_valid,
  output logic            frm_ready,
  input  logic            frm_ide,
  input  logic [28:0]     frm_id,
  output logic            res_valid,
  input  logic            res_ready,
  output logic            res_accept,
  output logic            res_fifo,
  output logic [IDXW-1:0] res_index
);
  localparam int SCW = $clog2(STD_N + 1);
  localparam int ECW = $clog2(EXT_N + 1);

  elem_t           elem;
  logic [28:0]     xmask;
  logic [1:0]      s_rule, e_rule;
  logic [SCW-1:0]  s_cnt;
  logic [ECW-1:0]  e_cnt;
  logic            scan_ext;
  logic [IDXW-1:0] scan_idx;
  logic [28:0]     scan_id;
  logic            hit;
  logic unused_addr;

  assign unused_addr = ^cfg_addr[1:0];

  can_flt_store #(.STD_N(STD_N), .EXT_N(EXT_N), .AW(AW), .IDXW(IDXW),
                  .SCW(SCW), .ECW(ECW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_word(cfg_addr[AW+1:2]), .wr_data(cfg_wdata),
    .rd_ext(scan_ext), .rd_idx(scan_idx), .rd_elem(elem),
    .xmask(xmask), .s_rule(s_rule), .e_rule(e_rule),
    .s_cnt(s_cnt), .e_cnt(e_cnt)
  );

  can_flt_match u_match (.elem(elem), .id(scan_id), .hit(hit));

  can_flt_seq #(.STD_N(STD_N), .EXT_N(EXT_N), .IDXW(IDXW),
                .SCW(SCW), .ECW(ECW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_ide(frm_ide), .frm_id(frm_id),
    .xmask(xmask), .s_rule(s_rule), .e_rule(e_rule),
    .s_cnt(s_cnt), .e_cnt(e_cnt),
    .hit(hit), .hit_act(elem.act),
    .scan_ext(scan_ext), .scan_idx(scan_idx), .scan_id(scan_id),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_accept(res_accept), .res_fifo(res_fifo), .res_index(res_index)
  );

  // R1: a stalled verdict holds all its fields
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_accept) && $stable(res_fifo) && $stable(res_index)));

  // R1: a taken frame closes the input until the verdict is consumed
  p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> !frm_ready);

  // R1: a consumed verdict reopens the input
  p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (frm_ready && !res_valid));
endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic        frm_ide = 1'b0;
  logic [28:0] frm_id = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_accept;
  logic        res_fifo;
  logic [4:0]  res_index;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  can_accept_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_ide(frm_ide), .frm_id(frm_id), .res_valid(res_valid),
    .res_ready(res_ready), .res_accept(res_accept), .res_fifo(res_fifo),
    .res_index(res_index)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(int word, int lowb, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 8'(word * 4 + lowb);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_std(int i, logic [1:0] t, logic [2:0] a, logic [10:0] i1, logic [10:0] i2);
    wr(i, 0, {t, a, i1, 5'd0, i2});
  endtask

  task automatic set_ext(int e, logic [1:0] t, logic [2:0] a, logic [28:0] i1, logic [28:0] i2, int lowb);
    wr(28 + 2 * e, lowb, {a, i1});
    wr(29 + 2 * e, lowb, {t, 1'b0, i2});
  endtask

  task automatic set_ctrl(logic [1:0] sr, logic [1:0] er, logic [4:0] sc, logic [3:0] ec);
    wr(44, 1, {12'd0, ec, 3'd0, sc, 4'd0, er, sr});
  endtask

  // Sends one frame and checks verdict and latency; optional stall checks R1.
  task automatic send(string tag, logic ide, logic [28:0] id, logic acc, logic fifo,
                      logic [4:0] idx, int lat, bit stall);
    int n;
    @(negedge clk);
    chk({tag, " R1 ready"}, 32'(frm_ready), 32'd1);
    frm_valid = 1'b1;
    frm_ide = ide;
    frm_id = id;
    @(posedge clk);
    n = 0;
    @(negedge clk);
    frm_valid = 1'b0;
    while (!res_valid && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk({tag, " latency"}, 32'(n), 32'(lat));
    chk({tag, " accept"}, 32'(res_accept), 32'(acc));
    chk({tag, " fifo"}, 32'(res_fifo), 32'(fifo));
    chk({tag, " index"}, 32'(res_index), 32'(idx));
    if (stall) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk({tag, " R1 hold"}, {res_valid, res_accept, res_fifo, res_index, frm_ready},
            {1'b1, acc, fifo, idx, 1'b0});
      end
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk({tag, " R1 drained"}, 32'(res_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R12 ready after reset", 32'(frm_ready), 32'd1);
    chk("R12 no verdict after reset", 32'(res_valid), 32'd0);
    send("R10 R12 empty list", 1'b0, 29'h123, 1, 0, 5'd31, 0, 0);
    send("R12 mask reset ones", 1'b1, 29'h1ABCDEF0, 1, 0, 5'd31, 0, 0);
  endtask

  task automatic t_types;
    set_std(0, 2'd0, 3'd2, 11'h100, 11'h1FF);
    set_std(1, 2'd0, 3'd1, 11'h300, 11'h2FF);
    set_std(2, 2'd1, 3'd1, 11'h055, 11'h066);
    set_std(3, 2'd2, 3'd3, 11'h520, 11'h7F0);
    set_ctrl(2'd2, 2'd0, 5'd4, 4'd0);
    send("R4 low bound", 1'b0, 29'h100, 1, 1, 5'd0, 1, 0);
    send("R4 high bound", 1'b0, 29'h1FF, 1, 1, 5'd0, 1, 0);
    send("R4 below R9 reject", 1'b0, 29'h0FF, 0, 0, 5'd31, 4, 0);
    send("R4 above", 1'b0, 29'h200, 0, 0, 5'd31, 4, 0);
    send("R4 reversed range", 1'b0, 29'h2FF, 0, 0, 5'd31, 4, 0);
    send("R5 second id", 1'b0, 29'h066, 1, 0, 5'd2, 3, 0);
    send("R5 first id", 1'b0, 29'h055, 1, 0, 5'd2, 3, 0);
    send("R5 miss", 1'b0, 29'h067, 0, 0, 5'd31, 4, 0);
    send("R6 R7 mask reject", 1'b0, 29'h52F, 0, 0, 5'd3, 4, 1);
    send("R6 mask miss", 1'b0, 29'h530, 0, 0, 5'd31, 4, 0);
  endtask

  task automatic t_order;
    set_std(4, 2'd1, 3'd2, 11'h52F, 11'h52F);
    set_ctrl(2'd1, 2'd0, 5'd5, 4'd0);
    send("R3 first hit wins", 1'b0, 29'h52F, 0, 0, 5'd3, 4, 0);
    set_std(3, 2'd2, 3'd0, 11'h520, 11'h7F0);
    send("R7 disabled skipped", 1'b0, 29'h52F, 1, 1, 5'd4, 5, 0);
    set_std(3, 2'd2, 3'd4, 11'h520, 11'h7F0);
    send("R7 action 1xx skipped", 1'b0, 29'h52F, 1, 1, 5'd4, 5, 1);
    send("R9 rule fifo1", 1'b0, 29'h7FF, 1, 1, 5'd31, 5, 0);
  endtask

  task automatic t_count;
    set_ctrl(2'd1, 2'd0, 5'd4, 4'd0);
    send("R10 count stops scan", 1'b0, 29'h52F, 1, 1, 5'd31, 4, 0);
    set_ctrl(2'd0, 2'd0, 5'd31, 4'd0);
    send("R10 count clamped", 1'b0, 29'h7FE, 1, 0, 5'd31, 28, 0);
  endtask

  task automatic t_select;
    set_ctrl(2'd1, 2'd2, 5'd5, 4'd0);
    send("R2 base uses low 11 bits", 1'b0, 29'h1FFFF866, 1, 0, 5'd2, 3, 0);
    send("R2 extended list chosen", 1'b1, 29'h066, 0, 0, 5'd31, 0, 0);
  endtask

  task automatic t_ext;
    set_ext(0, 2'd2, 3'd2, 29'h12345000, 29'h1FFFF000, 0);
    set_ext(1, 2'd0, 3'd1, 29'h10, 29'h20, 3);
    set_ctrl(2'd1, 2'd1, 5'd5, 4'd2);
    send("R6 extended mask hit", 1'b1, 29'h12345ABC, 1, 1, 5'd0, 1, 0);
    send("R11 R4 extended range", 1'b1, 29'h15, 1, 0, 5'd1, 2, 0);
    send("R9 extended no match", 1'b1, 29'h21, 1, 1, 5'd31, 2, 0);
    send("R2 base list for base frame", 1'b0, 29'h15, 1, 1, 5'd31, 5, 0);
    wr(45, 2, 32'h0FFFFFFF);
    send("R8 mask clears bit 28", 1'b1, 29'h12345000, 1, 1, 5'd31, 2, 0);
    wr(45, 0, 32'h0000001F);
    send("R8 masked into range", 1'b1, 29'h1FFFFF15, 1, 0, 5'd1, 2, 0);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_types();
    t_order();
    t_count();
    t_select();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule